// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of an SDRAM read or write burst. A one-cycle start pulse loads a start column together with a burst length code and an ordering select. From the next cycle the block puts out one column per clock with a beat-valid strobe and flags the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the burst-aligned block that holds the start column, in either sequential or interleaved order. A full-page burst walks the whole 256-column row, wraps around, and runs until it is stopped. A stop input ends a burst early, and a new start cancels whatever is running.

The controller around the block keeps data movement, CAS latency and command encoding. This block only tracks which column comes next.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `beat_vld_o` and `last_o` are 0, and `col_o` is 0 whenever `beat_vld_o` is 0.
- R2: A cycle with `start_i` high is followed in the next cycle by beat 0, with `beat_vld_o` high and `col_o` equal to the `start_col_i` sampled at the start edge.
- R3: `bl_sel_i` codes 0, 1, 2 and 3 select fixed bursts of 1, 2, 4 and 8 beats. With no stop and no restart, exactly that many consecutive valid beats are emitted, and `beat_vld_o` is 0 in the following cycle.
- R4: When `interleave_i` is 0 on a fixed burst of length L, beat n carries `(start & ~(L-1)) | ((start + n) & (L-1))`, so the upper column bits stay fixed.
- R5: When `interleave_i` is 1 on a fixed burst of length L, beat n carries `(start & ~(L-1)) | ((start ^ n) & (L-1))`.
- R6: `bl_sel_i` codes 4 to 7 select full page. Beat n carries `(start + n) mod 256`, wrapping from 255 to 0, and `interleave_i` has no effect. The burst keeps emitting beats, including beyond 256 of them.
- R7: `last_o` is high only on the final beat of a fixed burst and never during a full-page burst.
- R8: `stop_i` high during a valid beat makes `beat_vld_o` 0 in the next cycle. `stop_i` while idle has no effect.
- R9: `start_i` during a burst cancels the remaining beats, and beat 0 of the new burst follows in the next cycle. `start_i` takes priority over `stop_i` in the same cycle.
- R10: Start column, length code and ordering are sampled only at start. Changes to these inputs during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst (one-cycle pulse) |
| start_col_i | input | 8 | Start column for the new burst |
| bl_sel_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| interleave_i | input | 1 | 1 selects interleaved order for fixed bursts |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | 8 | Column address of the current beat |
| beat_vld_o | output | 1 | A burst beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A corrupted beat counter or latched mask shows up as a wrong `col_o` on the very next beat. A missed or extra end condition shows up as a strobe that drops early, or as a beat too many, one cycle after the expected final beat. Each fixed burst is compared beat by beat against the ordering formulas, with the start-time inputs scrambled during the burst. A full-page run past 256 beats shows that the wrap is correct and that the burst does not stop by itself.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;

    // Beat ordering latched for a running burst
    typedef enum logic [1:0] {
        ORD_SEQ  = 2'd0,
        ORD_ILV  = 2'd1,
        ORD_PAGE = 2'd2
    } order_e;

    // Length codes below this value are fixed bursts of 2**code beats
    localparam int FIXED_CODES = 4;

endpackage

// File: rtl/sdcol_len_dec.sv
module sdcol_len_dec
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BLS_W = 3
) (
    input  logic [BLS_W-1:0] bl_sel_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] mask_o,
    output order_e           order_o
);

    logic is_page;

    assign is_page = (int'(bl_sel_i) >= FIXED_CODES);

    // One mask bit per column bit: set when that bit lies inside the burst block
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = is_page ? 1'b1 : (i < int'(bl_sel_i));
    end

    always_comb begin
        if (is_page)
            order_o = ORD_PAGE;
        else if (interleave_i)
            order_o = ORD_ILV;
        else
            order_o = ORD_SEQ;
    end

endmodule

// File: rtl/sdcol_addr_gen.sv
module sdcol_addr_gen
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] flip;

    assign sum  = base_i + beat_i;
    assign flip = base_i ^ beat_i;

    // Bits inside the block follow the ordering; bits above it keep the base
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask_i[i])
                col_o[i] = base_i[i];
            else if (order_i == ORD_ILV)
                col_o[i] = flip[i];
            else
                col_o[i] = sum[i];
        end
    end

endmodule

// File: rtl/sdcol_ctrl.sv
module sdcol_ctrl
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output order_e           order_o
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        order_e           order;
    } state_t;

    state_t st_d, st_q;
    logic   final_beat;

    // A full-page burst never reaches a final beat
    assign final_beat = st_q.active && (st_q.order != ORD_PAGE)
                        && (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.beat   = '0;
            st_d.mask   = mask_i;
            st_d.order  = order_i;
        end else if (st_q.active && (stop_i || final_beat)) begin
            st_d.active = 1'b0;
            st_d.beat   = '0;
        end else if (st_q.active) begin
            st_d.beat   = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, base: '0, beat: '0, mask: '0, order: ORD_SEQ};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign last_o   = final_beat;
    assign base_o   = st_q.base;
    assign beat_o   = st_q.beat;
    assign mask_o   = st_q.mask;
    assign order_o  = st_q.order;

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BLS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [BLS_W-1:0] bl_sel_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);

    logic [COL_W-1:0] dec_mask;
    order_e           dec_order;
    logic             act;
    logic             fin;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    order_e           order_q;
    logic [COL_W-1:0] col_raw;

    sdcol_len_dec #(.COL_W(COL_W), .BLS_W(BLS_W)) u_dec (
        .bl_sel_i     (bl_sel_i),
        .interleave_i (interleave_i),
        .mask_o       (dec_mask),
        .order_o      (dec_order)
    );

    sdcol_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .order_i     (dec_order),
        .active_o    (act),
        .last_o      (fin),
        .base_o      (base_q),
        .beat_o      (beat_q),
        .mask_o      (mask_q),
        .order_o     (order_q)
    );

    sdcol_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i  (base_q),
        .beat_i  (beat_q),
        .mask_i  (mask_q),
        .order_i (order_q),
        .col_o   (col_raw)
    );

    assign col_o      = act ? col_raw : '0;
    assign beat_vld_o = act;
    assign last_o     = fin;

endmodule

// File: rtl/sdcol_chk.sv
module sdcol_chk #(
    parameter int COL_W = 8,
    parameter int BLS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [BLS_W-1:0] bl_sel_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o
);

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

    // R7
    last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    // R3
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !beat_vld_o);

    // R6
    page_keeps_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o && !stop_i && !start_i) |=> beat_vld_o);

    // R7
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && int'(bl_sel_i) >= 4) |=> !last_o);

endmodule

bind sdram_col_seq sdcol_chk #(.COL_W(COL_W), .BLS_W(BLS_W)) u_sdcol_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .bl_sel_i    (bl_sel_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o)
);

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_sel_i = '0;
    logic       interleave_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_col_seq i_sdram_col_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .bl_sel_i     (bl_sel_i),
        .interleave_i (interleave_i),
        .stop_i       (stop_i),
        .col_o        (col_o),
        .beat_vld_o   (beat_vld_o),
        .last_o       (last_o)
    );

    // {start column, length code, interleave}
    localparam logic [11:0] VEC [0:7] = '{
        {8'h35, 3'd0, 1'b0},
        {8'h35, 3'd1, 1'b0},
        {8'h35, 3'd1, 1'b1},
        {8'h36, 3'd2, 1'b0},
        {8'h3D, 3'd3, 1'b0},
        {8'h3D, 3'd3, 1'b1},
        {8'hFE, 3'd2, 1'b1},
        {8'hC3, 3'd3, 1'b0}
    };

    function automatic logic [7:0] exp_col(input logic [7:0] b, input int n,
                                           input logic [2:0] bl, input logic il);
        logic [7:0] m;
        logic [7:0] nn;
        nn = 8'(n);
        if (bl >= 3'd4) return b + nn;
        m = 8'((1 << bl) - 1);
        if (il) return (b & ~m) | ((b ^ nn) & m);
        return (b & ~m) | ((b + nn) & m);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; leaves with the first beat visible
    task automatic pulse_start(input logic [7:0] c, input logic [2:0] bl, input logic il,
                               input logic stp);
        start_i = 1'b1; start_col_i = c; bl_sel_i = bl; interleave_i = il; stop_i = stp;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        // R10: scramble sampled-at-start inputs during the burst
        start_col_i = ~c; bl_sel_i = bl ^ 3'd1; interleave_i = ~il;
    endtask

    task automatic check_beats(input logic [7:0] c, input logic [2:0] bl, input logic il,
                               input int cnt, input bit is_fixed, input string tag);
        for (int n = 0; n < cnt; n++) begin
            chk(beat_vld_o == 1'b1, {tag, " vld"}, int'(beat_vld_o), 1);
            chk(col_o == exp_col(c, n, bl, il), {tag, " col"}, int'(col_o),
                int'(exp_col(c, n, bl, il)));
            chk(last_o == (is_fixed && n == cnt - 1), "R7 last", int'(last_o),
                int'(is_fixed && n == cnt - 1));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(beat_vld_o == 1'b0, "R1 vld", int'(beat_vld_o), 0);
        chk(last_o == 1'b0, "R1 last", int'(last_o), 0);
        chk(col_o == 8'h00, "R1 col", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o == 1'b0, "R1 idle after release", int'(beat_vld_o), 0);

        // R2 R3 R4 R5 R10: table of fixed bursts
        for (int v = 0; v < 8; v++) begin
            logic [7:0] c;
            logic [2:0] bl;
            logic       il;
            {c, bl, il} = VEC[v];
            pulse_start(c, bl, il, 1'b0);
            check_beats(c, bl, il, 1 << bl, 1'b1, il ? "R5" : "R4");
            chk(beat_vld_o == 1'b0, "R3 end", int'(beat_vld_o), 0);
            chk(col_o == 8'h00, "R1 idle col", int'(col_o), 0);
            @(negedge clk);
        end

        // R6: full page from 0xFA, interleave ignored, runs past 256 beats
        pulse_start(8'hFA, 3'd7, 1'b1, 1'b0);
        check_beats(8'hFA, 3'd7, 1'b0, 300, 1'b0, "R6");
        // R8: stop ends the page burst
        stop_i = 1'b1;
        chk(beat_vld_o == 1'b1, "R8 beat during stop", int'(beat_vld_o), 1);
        @(negedge clk);
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b0, "R8 stopped", int'(beat_vld_o), 0);
        // R8: stop while idle has no effect
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b0, "R8 idle stop", int'(beat_vld_o), 0);
        pulse_start(8'h20, 3'd1, 1'b0, 1'b0);
        check_beats(8'h20, 3'd1, 1'b0, 2, 1'b1, "R8 after idle stop");

        // R9: restart mid-burst, with stop in the same cycle
        @(negedge clk);
        pulse_start(8'h10, 3'd3, 1'b0, 1'b0);
        check_beats(8'h10, 3'd3, 1'b0, 3, 1'b0, "R9 first");
        pulse_start(8'h47, 3'd2, 1'b1, 1'b1);
        check_beats(8'h47, 3'd2, 1'b1, 4, 1'b1, "R9 restart");
        chk(beat_vld_o == 1'b0, "R9 end", int'(beat_vld_o), 0);

        // R7: page code 4 with sequential order also never raises last
        pulse_start(8'hFF, 3'd4, 1'b0, 1'b0);
        check_beats(8'hFF, 3'd4, 1'b0, 10, 1'b0, "R7 page");
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b0, "R8 stop page", int'(beat_vld_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule